// File: doc/BRIEF.md
# Directory-Filtered Snoop Controller

This block is the coherence point for a group of cluster ports on one die plus a single chip-to-chip proxy port. A cluster's L2 presents a coherent request (a read, or a write/invalidate) for a line. The controller reads a presence directory that holds one bit per port for every line, and snoops only the ports whose bit is set. Copies on the other socket are reached through the proxy port, which holds no data of its own and answers slowly and with no fixed latency. Once every targeted port has answered, the request completes. If no port supplied the line, the request first goes out to the last-level cache.

A configuration pin turns filtering off. In that case every request is broadcast to all other ports, so the snoop traffic of the two modes can be compared. The directory is kept up to date in both modes. The controller works on one request at a time. Request, snoop, L3 and completion channels use valid/ready. A valid, once raised, holds itself and its payload steady until the matching ready is seen at a clock edge. Snoop responses have no ready: a response pulse counts only for a port that has been snooped and has not yet answered. The responder may not stall it.

Top module: `snoop_filter_ctrl`

## Requirements
- R1: After reset, req_ready is 1, snp_valid is all zero, and l3_valid and cmp_valid are 0. Every directory entry is empty.
- R2: Ports 0 to NLOCAL-1 are local clusters and port NLOCAL is the proxy. The requesting port (req_src) is never snooped.
- R3: With dir_en=1, the snooped set is exactly the presence bits recorded for req_line, minus the requester. An empty set issues no snoop and goes straight to L3.
- R4: With dir_en=0, every one of the NP-1 ports other than the requester is snooped, whatever the directory holds.
- R5: A responding port with rsp_hit=1 supplies the data. If no snooped port responds with rsp_hit=1, l3_valid is raised before completion and cmp_from_l3 is 1. Otherwise there is no L3 request and cmp_from_l3 is 0.
- R6: A completed read (req_write=0) adds the requester's presence bit for the line and keeps the other bits.
- R7: A completed write (req_write=1) leaves the requester as the line's only sharer. Its snoops carry snp_inv=1, and reads carry snp_inv=0.
- R8: Responses may arrive in any order and after any delay, the proxy's included. Completion waits for one response from every snooped port. Responses on ports that were not snooped are ignored.
- R9: Only one request is in flight. req_ready is 0 from acceptance until the completion handshake.
- R10: Each of snp_valid[i], l3_valid and cmp_valid stays asserted with a stable payload until its ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_en | input | 1 | 1 = directory filtering, 0 = broadcast |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_src | input | PW | Requesting port index |
| req_line | input | LW | Line address |
| req_write | input | 1 | 1 = write/invalidate, 0 = read |
| snp_valid | output | NP | Per-port snoop valid |
| snp_ready | input | NP | Per-port snoop ready |
| snp_line | output | LW | Snooped line |
| snp_inv | output | 1 | Snoop is an invalidation |
| rsp_valid | input | NP | Per-port snoop response pulse |
| rsp_hit | input | NP | Per-port: responder supplied data |
| l3_valid | output | 1 | Last-level cache request valid |
| l3_ready | input | 1 | Last-level cache request ready |
| l3_line | output | LW | Line sent to last-level cache |
| cmp_valid | output | 1 | Completion valid |
| cmp_ready | input | 1 | Completion ready |
| cmp_from_l3 | output | 1 | Data came from last-level cache |

## Verification
On every cycle the assertions check the following. The requester is never in the snoop set. Nothing is in flight while the request channel is ready. L3 is never asked while a peer has supplied data. Each valid holds with a stable payload until its ready. Other behaviours can only be shown by the bench's scenarios, which run sweeps of sources, lines and operations in both modes and drive varied ready and response timing: that the snoop set matches the directory contents built up by earlier reads and writes, that broadcast mode snoops every other port, and that responses from ports outside the snoop set are ignored.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SNOOP = 2'd1,
    ST_L3    = 2'd2,
    ST_CMP   = 2'd3
  } sfc_state_e;
endpackage

// File: rtl/sfc_presence.sv
// Presence table: one sharer bit per port for every tracked line.
module sfc_presence #(
  parameter int NP    = 5,
  parameter int LINES = 16,
  localparam int PW = $clog2(NP),
  localparam int LW = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] rd_line,
  output logic [NP-1:0] rd_pres,
  input  logic          upd_en,
  input  logic [LW-1:0] upd_line,
  input  logic [PW-1:0] upd_src,
  input  logic          upd_excl
);
  logic [NP-1:0] pres_q [LINES];
  logic [NP-1:0] src_bit;

  assign src_bit = {{(NP-1){1'b0}}, 1'b1} << upd_src;
  assign rd_pres = pres_q[rd_line];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pres_q[g] <= '0;
      end else if (upd_en && upd_line == LW'(g)) begin
        pres_q[g] <= upd_excl ? src_bit : (pres_q[g] | src_bit);
      end
    end
  end
endmodule

// File: rtl/sfc_collect.sv
// Tracks which snoops are still to be issued and which responses are owed.
module sfc_collect #(
  parameter int NP = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [NP-1:0] load_mask,
  output logic [NP-1:0] snp_valid,
  input  logic [NP-1:0] snp_ready,
  input  logic [NP-1:0] rsp_valid,
  input  logic [NP-1:0] rsp_hit,
  output logic          all_done,
  output logic          any_hit
);
  logic [NP-1:0] pend_iss_q, pend_rsp_q;
  logic [NP-1:0] rsp_take;
  logic          hit_q;

  assign snp_valid = pend_iss_q;
  assign rsp_take  = rsp_valid & pend_rsp_q & ~pend_iss_q;
  assign all_done  = (pend_iss_q == '0) && (pend_rsp_q == '0);
  assign any_hit   = hit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_iss_q <= '0;
      pend_rsp_q <= '0;
      hit_q      <= 1'b0;
    end else if (load) begin
      pend_iss_q <= load_mask;
      pend_rsp_q <= load_mask;
      hit_q      <= 1'b0;
    end else begin
      pend_iss_q <= pend_iss_q & ~snp_ready;
      pend_rsp_q <= pend_rsp_q & ~rsp_take;
      hit_q      <= hit_q | (|(rsp_take & rsp_hit));
    end
  end
endmodule

// File: rtl/snoop_filter_ctrl.sv
module snoop_filter_ctrl #(
  parameter int NLOCAL = 4,
  parameter int LINES  = 16,
  localparam int NP = NLOCAL + 1,
  localparam int PW = $clog2(NP),
  localparam int LW = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_en,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [PW-1:0] req_src,
  input  logic [LW-1:0] req_line,
  input  logic          req_write,
  output logic [NP-1:0] snp_valid,
  input  logic [NP-1:0] snp_ready,
  output logic [LW-1:0] snp_line,
  output logic          snp_inv,
  input  logic [NP-1:0] rsp_valid,
  input  logic [NP-1:0] rsp_hit,
  output logic          l3_valid,
  input  logic          l3_ready,
  output logic [LW-1:0] l3_line,
  output logic          cmp_valid,
  input  logic          cmp_ready,
  output logic          cmp_from_l3
);
  import sfc_pkg::*;

  sfc_state_e    state_q;
  logic [PW-1:0] src_q;
  logic [LW-1:0] line_q;
  logic          wr_q, from_l3_q;
  logic [NP-1:0] dir_pres, self_bit, target;
  logic          accept, col_done, col_hit, upd_en;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign self_bit  = {{(NP-1){1'b0}}, 1'b1} << req_src;
  assign target    = (dir_en ? dir_pres : {NP{1'b1}}) & ~self_bit;
  assign upd_en    = (state_q == ST_CMP) && cmp_ready;

  sfc_presence #(.NP(NP), .LINES(LINES)) u_dir (
    .clk(clk), .rst_n(rst_n),
    .rd_line(req_line), .rd_pres(dir_pres),
    .upd_en(upd_en), .upd_line(line_q), .upd_src(src_q), .upd_excl(wr_q)
  );

  sfc_collect #(.NP(NP)) u_col (
    .clk(clk), .rst_n(rst_n),
    .load(accept), .load_mask(target),
    .snp_valid(snp_valid), .snp_ready(snp_ready),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .all_done(col_done), .any_hit(col_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      src_q     <= '0;
      line_q    <= '0;
      wr_q      <= 1'b0;
      from_l3_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          src_q   <= req_src;
          line_q  <= req_line;
          wr_q    <= req_write;
          state_q <= (target == '0) ? ST_L3 : ST_SNOOP;
        end
        ST_SNOOP: if (col_done) begin
          from_l3_q <= !col_hit;
          state_q   <= col_hit ? ST_CMP : ST_L3;
        end
        ST_L3: if (l3_ready) begin
          from_l3_q <= 1'b1;
          state_q   <= ST_CMP;
        end
        ST_CMP: if (cmp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign snp_line    = line_q;
  assign snp_inv     = wr_q;
  assign l3_line     = line_q;
  assign l3_valid    = (state_q == ST_L3);
  assign cmp_valid   = (state_q == ST_CMP);
  assign cmp_from_l3 = from_l3_q;
endmodule

// File: rtl/sfc_checker.sv
module sfc_checker #(
  parameter int NP = 5,
  parameter int PW = 3,
  parameter int LW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic [NP-1:0] snp_valid,
  input logic [NP-1:0] snp_ready,
  input logic [LW-1:0] snp_line,
  input logic          l3_valid,
  input logic          l3_ready,
  input logic [LW-1:0] l3_line,
  input logic          cmp_valid,
  input logic          cmp_ready,
  input logic          cmp_from_l3,
  input logic [PW-1:0] src_q,
  input logic          col_hit
);
  // R2
  a_r2_no_self_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid[src_q] == 1'b0);
  // R5
  a_r5_no_l3_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
    l3_valid |-> !col_hit);
  // R9
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (snp_valid == '0 && !l3_valid && !cmp_valid));
  // R10
  a_r10_snp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid & ~snp_ready) != '0 |=>
      ((snp_valid & $past(snp_valid & ~snp_ready)) == $past(snp_valid & ~snp_ready))
      && $stable(snp_line));
  a_r10_l3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    l3_valid && !l3_ready |=> l3_valid && $stable(l3_line));
  a_r10_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && !cmp_ready |=> cmp_valid && $stable(cmp_from_l3));
endmodule

bind snoop_filter_ctrl sfc_checker #(.NP(NP), .PW(PW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .snp_valid(snp_valid), .snp_ready(snp_ready), .snp_line(snp_line),
  .l3_valid(l3_valid), .l3_ready(l3_ready), .l3_line(l3_line),
  .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .cmp_from_l3(cmp_from_l3),
  .src_q(src_q), .col_hit(col_hit)
);

// File: tb/snoop_filter_ctrl_tb.sv
module snoop_filter_ctrl_tb;
  localparam int NLOCAL = 4;
  localparam int LINES  = 16;
  localparam int NP = NLOCAL + 1;
  localparam int PW = $clog2(NP);
  localparam int LW = $clog2(LINES);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_en = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic req_ready;
  logic [PW-1:0] req_src = '0;
  logic [LW-1:0] req_line = '0;
  logic [NP-1:0] snp_valid, snp_ready = '0, rsp_valid = '0, rsp_hit = '0;
  logic [LW-1:0] snp_line, l3_line;
  logic snp_inv, l3_valid, l3_ready = 1'b0, cmp_valid, cmp_ready = 1'b0, cmp_from_l3;

  int errors = 0, checks = 0;
  logic [NP-1:0] ref_pres [LINES];
  int snoops_seen = 0, snoops_exp = 0;

  always #5 clk = ~clk;

  snoop_filter_ctrl #(.NLOCAL(NLOCAL), .LINES(LINES)) u_dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_req(input int src, input int line, input bit wr, input logic [NP-1:0] hitm);
    logic [NP-1:0] self_b, exp_t, obs, issued;
    int due [NP];
    bit l3_seen, done, inv_ok, cmp_seen, l3_exp;
    int l3_cnt, cyc, spur;
    self_b = NP'(1) << src;
    exp_t  = (dir_en ? ref_pres[line] : {NP{1'b1}}) & ~self_b;
    l3_exp = ((hitm & exp_t) == '0);
    obs = '0; issued = '0; l3_seen = 0; done = 0; inv_ok = 1; cmp_seen = 0; l3_cnt = 0;
    for (int i = 0; i < NP; i++) due[i] = -1;
    spur = -1;
    for (int i = 0; i < NP; i++) if (!exp_t[i] && i != src) spur = i;
    @(negedge clk);
    check(req_ready == 1'b1, "R9 ready when idle", req_ready, 1);
    req_valid = 1'b1; req_src = PW'(src); req_line = LW'(line); req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R9 busy after accept", req_ready, 0);
    cyc = 0;
    while (!done && cyc < 200) begin
      cyc++;
      rsp_valid = '0; rsp_hit = '0;
      // R8: stray response on a port that was not snooped
      if (cyc == 1 && spur >= 0) begin
        rsp_valid[spur] = 1'b1; rsp_hit[spur] = 1'b1;
      end
      for (int i = 0; i < NP; i++)
        snp_ready[i] = (i == NLOCAL) ? ((cyc % 4) == 3) : (((cyc + i) % 3) != 0);
      for (int i = 0; i < NP; i++) begin
        if (snp_valid[i]) begin
          obs[i] = 1'b1;
          if (snp_inv != wr || snp_line != LW'(line)) inv_ok = 0;
          if (snp_ready[i] && !issued[i]) begin
            issued[i] = 1'b1;
            due[i] = cyc + 1 + ((i * 3 + line + src) % 4) + ((i == NLOCAL) ? 5 : 0);
          end
        end
        if (due[i] == cyc) begin
          rsp_valid[i] = 1'b1; rsp_hit[i] = hitm[i];
        end
      end
      if (l3_valid) begin
        l3_seen = 1; l3_cnt++;
        l3_ready = (l3_cnt >= 2);
      end else l3_ready = 1'b0;
      if (cmp_valid) begin
        cmp_ready = cmp_seen;
        if (cmp_seen) begin
          done = 1;
          check(cmp_from_l3 == l3_exp, "R5 cmp_from_l3", cmp_from_l3, l3_exp);
        end
        cmp_seen = 1;
      end else cmp_ready = 1'b0;
      @(negedge clk);
    end
    rsp_valid = '0; rsp_hit = '0; snp_ready = '0; l3_ready = 0; cmp_ready = 0;
    check(done, "R8 completion within watchdog", done, 1);
    if (dir_en) check(obs == exp_t, "R3 filtered snoop set", obs, exp_t);
    else        check(obs == exp_t, "R4 broadcast snoop set", obs, exp_t);
    check(obs[src] == 1'b0, "R2 requester not snooped", obs, exp_t);
    check(l3_seen == l3_exp, "R5 L3 forward", l3_seen, l3_exp);
    check(inv_ok, "R7 snoop inv flag and line", inv_ok, 1);
    snoops_seen += $countones(obs);
    snoops_exp  += $countones(exp_t);
    // R6 / R7 reference update
    ref_pres[line] = wr ? self_b : (ref_pres[line] | self_b);
  endtask

  initial begin
    for (int l = 0; l < LINES; l++) ref_pres[l] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && snp_valid == '0 && !l3_valid && !cmp_valid,
          "R1 reset state", {req_ready, snp_valid, l3_valid, cmp_valid}, 8'h80);
    // R3: fresh line has no sharers -> straight to L3 with no snoops
    run_req(0, 5, 1'b0, '1);
    // R6: build sharers by reads, R3 snoop set follows them
    run_req(1, 5, 1'b0, '0);
    run_req(NLOCAL, 5, 1'b0, 5'b00010);
    run_req(2, 5, 1'b0, 5'b10000);
    // R7: write leaves only the writer
    run_req(3, 5, 1'b1, 5'b00001);
    run_req(0, 5, 1'b0, 5'b01000);
    // Directory-mode sweep
    dir_en = 1'b1;
    for (int l = 0; l < LINES; l++)
      for (int s = 0; s < NP; s++)
        run_req(s, l, ((l + s) % 3) == 0, NP'((l * 7 + s * 3) & 31));
    // R4: broadcast sweep
    dir_en = 1'b0;
    for (int l = 0; l < 8; l++)
      for (int s = 0; s < NP; s++)
        run_req(s, l, ((l + 2 * s) % 4) == 1, NP'((l * 5 + s) & 31));
    // Back to filtered: directory was maintained during broadcast
    dir_en = 1'b1;
    for (int s = 0; s < NP; s++) run_req(s, 3, 1'b0, '0);
    check(snoops_seen == snoops_exp, "R3 R4 total snoop count", snoops_seen, snoops_exp);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R8 watchdog expired: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule